// File: doc/BRIEF.md
# Serial Channel Command and Mode Registers

This block is the control plane of one asynchronous serial channel inside a multi-channel serial controller. It sits on a byte-wide register bus. It decodes the channel's four register offsets and keeps the frame configuration that a separate shift-register core needs: character length, parity, stop length, FIFO options, baud table selection and the clock-select byte. It also drives the receiver and transmitter enables, one-cycle flush strobes, and a break control for the transmit line.

Software reaches the three mode registers through a pointer. Command codes set the pointer, and each write to the mode offset moves it forward. The same command byte can also enable or disable either direction, reset either direction, clear latched errors, clear the break-change flag, and start or stop a break. A status byte combines ready and empty indications from the core with sticky error flags. The serializer, deserializer, FIFOs and baud generator live outside this block. They reach it only as level inputs, event strobes and push/pop strobes.

Top module: `sercfg_chan`

## Requirements
- R1: The channel answers only to addresses whose bits above the low three equal CH_IDX (registers at CH_IDX*8). Offset 0 is mode, offset 1 is status on read and clock select on write, offset 2 is command (write), and offset 3 is the holding register. Accesses aimed at another channel change nothing.
- R2: Command bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. When enable and disable are both set for one direction, disable wins. The new state is visible after the write edge.
- R3: Hardware reset points the mode pointer at mode register 1. Command code 0x1 (bits 7:4) points it at mode register 1 and code 0xB at mode register 0. Each mode-offset write goes to the pointed register and then moves the pointer 0→1→2, where it stays at 2. A mode-offset read returns the pointed register.
- R4: Mode register 1 bits 1:0 give the word-length code (0..3 for 5..8 bits). Bit 4 set means no parity (code 4 in bits 4:2). With bit 4 clear, parity is enabled and bit 2 selects odd (1) or even (0).
- R5: Mode register 2 bit 3 selects two stop bits, so a low nibble of 0xF gives two stop bits and 0x7 gives one.
- R6: Mode register 0 bit 3 enables the FIFO, bit 4 selects the half-full transmit level, and bits 2:0 are the baud table select (0 normal, 1 or 5 extended).
- R7: Command code 0x2 pulses rx_flush and code 0x3 pulses tx_flush, each for exactly the one cycle after the write edge. Neither moves the mode pointer.
- R8: Status bits: 0 receive ready (rx_avail), 1 receive full (rx_full), 2 transmit ready (tx_space while transmitter enabled), 3 transmitter empty (tx_idle while transmitter enabled), 5 parity error and 6 framing error (head flags, only while rx_avail).
- R9: Status bit 4 (overrun) and bit 7 (received break) latch on their event strobes and stay set until command code 0x4.
- R10: brk_change latches on a received-break strobe and clears only on command code 0x5.
- R11: After command code 0x6, line_brk rises on the first clock edge at which tx_idle is high, and it stays high until command code 0x7.
- R12: A write to the holding offset pulses tx_push, combinationally, with tx_data equal to the written byte. A read of it returns rx_data and pulses rx_pop.
- R13: A write to offset 1 stores the byte on clk_sel. A read of offset 1 still returns status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address (channel index above the low 3 bits) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd addresses this channel |
| rx_avail | input | 1 | Receive FIFO holds a character |
| rx_full | input | 1 | Receive FIFO is full |
| tx_space | input | 1 | Transmit FIFO can accept a character |
| tx_idle | input | 1 | Transmit shifter and FIFO are empty |
| head_par_err | input | 1 | Parity error on the character at the receive head |
| head_frm_err | input | 1 | Framing error on the character at the receive head |
| rx_ovr_evt | input | 1 | One-cycle overrun event |
| rx_brk_evt | input | 1 | One-cycle received-break event |
| rx_data | input | 8 | Character at the receive head |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| rx_flush | output | 1 | One-cycle receiver reset strobe |
| tx_flush | output | 1 | One-cycle transmitter reset strobe |
| line_brk | output | 1 | Hold transmit line in break |
| brk_change | output | 1 | Latched break-change flag |
| word_len | output | 2 | Character length code (0..3 = 5..8 bits) |
| par_en | output | 1 | Parity enabled |
| par_odd | output | 1 | Odd parity when enabled |
| stop_two | output | 1 | Two stop bits |
| fifo_en | output | 1 | FIFO enable |
| tx_half | output | 1 | Half-full transmit level select |
| baud_ext | output | 3 | Baud table select |
| clk_sel | output | 8 | Clock-select byte |
| tx_push | output | 1 | Holding-register write strobe to the transmit FIFO |
| tx_data | output | 8 | Byte to push |
| rx_pop | output | 1 | Holding-register read strobe to the receive FIFO |

## Verification
The assertions assume that the event strobes rx_ovr_evt and rx_brk_evt are single-cycle pulses and that tx_idle is a clean level from the core. They also assume that bus_wr and bus_rd are never high together and only change between clock edges. The bench drives every bus and core input on the falling edge, keeps each strobe one cycle long, and never overlaps a read with a write. The property windows therefore see only legal stimulus.

// File: rtl/sercfg_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the serial channel control block.
// Assumes a byte-wide bus and an 8-byte register window per channel.
package sercfg_pkg;
    localparam int DATA_W = 8;
    localparam int OFS_W  = 3;

    // Register offsets inside the channel window
    localparam logic [OFS_W-1:0] OFS_MODE = 3'd0;
    localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CMD  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_HOLD = 3'd3;

    // Command codes in bits 7:4 of the command byte
    localparam logic [3:0] CC_PTR_M1   = 4'h1;
    localparam logic [3:0] CC_RX_RST   = 4'h2;
    localparam logic [3:0] CC_TX_RST   = 4'h3;
    localparam logic [3:0] CC_ERR_CLR  = 4'h4;
    localparam logic [3:0] CC_BCHG_CLR = 4'h5;
    localparam logic [3:0] CC_BRK_ON   = 4'h6;
    localparam logic [3:0] CC_BRK_OFF  = 4'h7;
    localparam logic [3:0] CC_PTR_M0   = 4'hB;

    // Status bit positions
    localparam int SB_RXRDY = 0;
    localparam int SB_RXFUL = 1;
    localparam int SB_TXRDY = 2;
    localparam int SB_TXEMT = 3;
    localparam int SB_OVR   = 4;
    localparam int SB_PAR   = 5;
    localparam int SB_FRM   = 6;
    localparam int SB_BRK   = 7;

    localparam int NUM_MR = 3;

    typedef enum logic [1:0] {PTR_M0 = 2'd0, PTR_M1 = 2'd1, PTR_M2 = 2'd2} mode_ptr_e;

    // Decoded one-cycle actions of a command write
    typedef struct packed {
        logic rx_on;
        logic rx_off;
        logic tx_on;
        logic tx_off;
        logic ptr_m1;
        logic ptr_m0;
        logic rx_rst;
        logic tx_rst;
        logic err_clr;
        logic bchg_clr;
        logic brk_on;
        logic brk_off;
    } cmd_t;
endpackage

// File: rtl/sercfg_decode.sv
`timescale 1ns/1ps
// Module: sercfg_decode
// Decodes bus accesses for one channel window and splits command writes
// into single-cycle actions. Assumes bus_wr and bus_rd are not both high.
module sercfg_decode
    import sercfg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CH_IDX = 0
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              mode_wr,
    output logic              csel_wr,
    output logic              hold_wr,
    output logic              hold_rd,
    output logic              mode_rd,
    output logic              stat_rd,
    output cmd_t              cmd
);
    localparam int CH_W = ADDR_W - OFS_W;

    logic             ch_hit;
    logic [OFS_W-1:0] ofs;
    logic             cmd_wr;
    logic [3:0]       code;

    // R1: channel window match and offset split
    assign ch_hit = (bus_addr[ADDR_W-1:OFS_W] == CH_W'(CH_IDX));
    assign ofs    = bus_addr[OFS_W-1:0];
    assign code   = bus_wdata[DATA_W-1:4];

    // Per-offset access strobes
    always_comb begin
        mode_wr = bus_wr && ch_hit && (ofs == OFS_MODE);
        csel_wr = bus_wr && ch_hit && (ofs == OFS_STAT);
        cmd_wr  = bus_wr && ch_hit && (ofs == OFS_CMD);
        hold_wr = bus_wr && ch_hit && (ofs == OFS_HOLD);
        mode_rd = bus_rd && ch_hit && (ofs == OFS_MODE);
        stat_rd = bus_rd && ch_hit && (ofs == OFS_STAT);
        hold_rd = bus_rd && ch_hit && (ofs == OFS_HOLD);
    end

    // Split a command byte into enable bits and one coded action
    always_comb begin
        cmd = '0;
        if (cmd_wr) begin
            cmd.rx_on  = bus_wdata[0];
            cmd.rx_off = bus_wdata[1];
            cmd.tx_on  = bus_wdata[2];
            cmd.tx_off = bus_wdata[3];
            case (code)
                CC_PTR_M1:   cmd.ptr_m1   = 1'b1;
                CC_RX_RST:   cmd.rx_rst   = 1'b1;
                CC_TX_RST:   cmd.tx_rst   = 1'b1;
                CC_ERR_CLR:  cmd.err_clr  = 1'b1;
                CC_BCHG_CLR: cmd.bchg_clr = 1'b1;
                CC_BRK_ON:   cmd.brk_on   = 1'b1;
                CC_BRK_OFF:  cmd.brk_off  = 1'b1;
                CC_PTR_M0:   cmd.ptr_m0   = 1'b1;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/sercfg_modefile.sv
`timescale 1ns/1ps
// Module: sercfg_modefile
// Holds the three mode registers behind an auto-advancing pointer plus the
// clock-select byte, and decodes the frame fields. Assumes pointer commands
// and mode writes never share a cycle (they use different offsets).
module sercfg_modefile
    import sercfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              csel_wr,
    input  logic              ptr_m1,
    input  logic              ptr_m0,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] clk_sel,
    output logic [1:0]        word_len,
    output logic              par_en,
    output logic              par_odd,
    output logic              stop_two,
    output logic              fifo_en,
    output logic              tx_half,
    output logic [2:0]        baud_ext
);
    mode_ptr_e                     ptr_q;
    logic [NUM_MR-1:0][DATA_W-1:0] mr_bus;

    // R3: pointer set by command, advanced by each mode write, saturating at 2
    always_ff @(posedge clk) begin
        if (!rst_n)          ptr_q <= PTR_M1;
        else if (ptr_m1)     ptr_q <= PTR_M1;
        else if (ptr_m0)     ptr_q <= PTR_M0;
        else if (mode_wr) begin
            case (ptr_q)
                PTR_M0:  ptr_q <= PTR_M1;
                default: ptr_q <= PTR_M2;
            endcase
        end
    end

    // One storage register per mode slot, written when the pointer selects it
    for (genvar i = 0; i < NUM_MR; i++) begin : g_mr
        logic [DATA_W-1:0] q;
        // Capture the write byte for slot i
        always_ff @(posedge clk) begin
            if (!rst_n)                                       q <= '0;
            else if (mode_wr && (ptr_q == mode_ptr_e'(i)))     q <= wdata;
        end
        assign mr_bus[i] = q;
    end

    // R13: clock-select byte
    always_ff @(posedge clk) begin
        if (!rst_n)       clk_sel <= '0;
        else if (csel_wr) clk_sel <= wdata;
    end

    // Readback of the pointed mode register
    always_comb begin
        case (ptr_q)
            PTR_M0:  mode_q = mr_bus[0];
            PTR_M1:  mode_q = mr_bus[1];
            default: mode_q = mr_bus[2];
        endcase
    end

    // R4 R5 R6: field decode
    always_comb begin
        word_len = mr_bus[1][1:0];
        par_en   = !mr_bus[1][4];
        par_odd  = !mr_bus[1][4] && mr_bus[1][2];
        stop_two = mr_bus[2][3];
        fifo_en  = mr_bus[0][3];
        tx_half  = mr_bus[0][4];
        baud_ext = mr_bus[0][2:0];
    end

    // R3: a pointer command lands on its target
    a_r3_ptr_cmd_m1: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_m1 |=> (ptr_q == PTR_M1));
    // R3: pointer stays at slot 2 under further mode writes
    a_r3_ptr_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == PTR_M2 && mode_wr && !ptr_m1 && !ptr_m0) |=> (ptr_q == PTR_M2));
    // R3: slot 0 write moves pointer to slot 1
    a_r3_ptr_from_m0: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == PTR_M0 && mode_wr && !ptr_m1 && !ptr_m0) |=> (ptr_q == PTR_M1));
endmodule

// File: rtl/sercfg_linectl.sv
`timescale 1ns/1ps
// Module: sercfg_linectl
// Receiver/transmitter enables, flush strobes and break control.
// Assumes tx_idle is a level from the core that is high when no character
// is being shifted out.
module sercfg_linectl
    import sercfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_t cmd,
    input  logic tx_idle,
    output logic rx_en,
    output logic tx_en,
    output logic rx_flush,
    output logic tx_flush,
    output logic line_brk
);
    logic brk_req_q;

    // R2: receiver enable, disable has priority
    always_ff @(posedge clk) begin
        if (!rst_n)          rx_en <= 1'b0;
        else if (cmd.rx_off) rx_en <= 1'b0;
        else if (cmd.rx_on)  rx_en <= 1'b1;
    end

    // R2: transmitter enable, disable has priority
    always_ff @(posedge clk) begin
        if (!rst_n)          tx_en <= 1'b0;
        else if (cmd.tx_off) tx_en <= 1'b0;
        else if (cmd.tx_on)  tx_en <= 1'b1;
    end

    // R7: one-cycle flush strobes after a reset command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
        end else begin
            rx_flush <= cmd.rx_rst;
            tx_flush <= cmd.tx_rst;
        end
    end

    // R11: break request latched until stop-break
    always_ff @(posedge clk) begin
        if (!rst_n)           brk_req_q <= 1'b0;
        else if (cmd.brk_off) brk_req_q <= 1'b0;
        else if (cmd.brk_on)  brk_req_q <= 1'b1;
    end

    // R11: line enters break once the transmitter is idle
    always_ff @(posedge clk) begin
        if (!rst_n)                       line_brk <= 1'b0;
        else if (cmd.brk_off)             line_brk <= 1'b0;
        else if (brk_req_q && tx_idle)    line_brk <= 1'b1;
    end

    // R2: disable command wins over enable
    a_r2_rx_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.rx_off |=> !rx_en);
    a_r2_tx_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.tx_off |=> !tx_en);
    // R11: break starts only when the shifter was idle
    a_r11_brk_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_brk) |-> $past(tx_idle));
    // R11: break holds until the stop command
    a_r11_brk_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (line_brk && !cmd.brk_off) |=> line_brk);
endmodule

// File: rtl/sercfg_status.sv
`timescale 1ns/1ps
// Module: sercfg_status
// Builds the status byte from core levels and latched error flags, and
// keeps the break-change flag. Assumes event inputs are one-cycle pulses.
module sercfg_status
    import sercfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_avail,
    input  logic              rx_full,
    input  logic              tx_space,
    input  logic              tx_idle,
    input  logic              tx_en,
    input  logic              head_par_err,
    input  logic              head_frm_err,
    input  logic              rx_ovr_evt,
    input  logic              rx_brk_evt,
    input  logic              err_clr,
    input  logic              bchg_clr,
    output logic [DATA_W-1:0] stat,
    output logic              brk_change
);
    logic ovr_q;
    logic brk_q;

    // R9: overrun latch, event wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)          ovr_q <= 1'b0;
        else if (rx_ovr_evt) ovr_q <= 1'b1;
        else if (err_clr)    ovr_q <= 1'b0;
    end

    // R9: received-break latch, event wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)          brk_q <= 1'b0;
        else if (rx_brk_evt) brk_q <= 1'b1;
        else if (err_clr)    brk_q <= 1'b0;
    end

    // R10: break-change latch
    always_ff @(posedge clk) begin
        if (!rst_n)          brk_change <= 1'b0;
        else if (rx_brk_evt) brk_change <= 1'b1;
        else if (bchg_clr)   brk_change <= 1'b0;
    end

    // R8: status byte assembly
    always_comb begin
        stat           = '0;
        stat[SB_RXRDY] = rx_avail;
        stat[SB_RXFUL] = rx_full;
        stat[SB_TXRDY] = tx_en && tx_space;
        stat[SB_TXEMT] = tx_en && tx_idle;
        stat[SB_OVR]   = ovr_q;
        stat[SB_PAR]   = rx_avail && head_par_err;
        stat[SB_FRM]   = rx_avail && head_frm_err;
        stat[SB_BRK]   = brk_q;
    end

    // R9: latched flags survive until the clear command
    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !err_clr) |=> ovr_q);
    a_r9_brk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_q && !err_clr) |=> brk_q);
    // R10: clear without a new event drops the flag
    a_r10_bchg_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bchg_clr && !rx_brk_evt) |=> !brk_change);
endmodule

// File: rtl/sercfg_chan.sv
`timescale 1ns/1ps
// Module: sercfg_chan (top)
// Control plane of one serial channel: bus decode, mode registers, line
// control and status. Assumes ADDR_W >= 4 and a single-cycle register bus.
module sercfg_chan
    import sercfg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_avail,
    input  logic              rx_full,
    input  logic              tx_space,
    input  logic              tx_idle,
    input  logic              head_par_err,
    input  logic              head_frm_err,
    input  logic              rx_ovr_evt,
    input  logic              rx_brk_evt,
    input  logic [7:0]        rx_data,
    output logic              rx_en,
    output logic              tx_en,
    output logic              rx_flush,
    output logic              tx_flush,
    output logic              line_brk,
    output logic              brk_change,
    output logic [1:0]        word_len,
    output logic              par_en,
    output logic              par_odd,
    output logic              stop_two,
    output logic              fifo_en,
    output logic              tx_half,
    output logic [2:0]        baud_ext,
    output logic [7:0]        clk_sel,
    output logic              tx_push,
    output logic [7:0]        tx_data,
    output logic              rx_pop
);
    logic              mode_wr, csel_wr, hold_wr, hold_rd, mode_rd, stat_rd;
    cmd_t              cmd;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] stat;

    sercfg_decode #(.ADDR_W(ADDR_W), .CH_IDX(CH_IDX)) u_dec (
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .mode_wr(mode_wr), .csel_wr(csel_wr), .hold_wr(hold_wr), .hold_rd(hold_rd),
        .mode_rd(mode_rd), .stat_rd(stat_rd), .cmd(cmd)
    );

    sercfg_modefile u_mode (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .csel_wr(csel_wr),
        .ptr_m1(cmd.ptr_m1), .ptr_m0(cmd.ptr_m0), .wdata(bus_wdata),
        .mode_q(mode_q), .clk_sel(clk_sel), .word_len(word_len), .par_en(par_en),
        .par_odd(par_odd), .stop_two(stop_two), .fifo_en(fifo_en),
        .tx_half(tx_half), .baud_ext(baud_ext)
    );

    sercfg_linectl u_line (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .tx_idle(tx_idle),
        .rx_en(rx_en), .tx_en(tx_en), .rx_flush(rx_flush), .tx_flush(tx_flush),
        .line_brk(line_brk)
    );

    sercfg_status u_stat (
        .clk(clk), .rst_n(rst_n), .rx_avail(rx_avail), .rx_full(rx_full),
        .tx_space(tx_space), .tx_idle(tx_idle), .tx_en(tx_en),
        .head_par_err(head_par_err), .head_frm_err(head_frm_err),
        .rx_ovr_evt(rx_ovr_evt), .rx_brk_evt(rx_brk_evt),
        .err_clr(cmd.err_clr), .bchg_clr(cmd.bchg_clr),
        .stat(stat), .brk_change(brk_change)
    );

    // R12: holding-register strobes toward the FIFOs
    assign tx_push = hold_wr;
    assign tx_data = bus_wdata;
    assign rx_pop  = hold_rd;

    // R1 R13: read mux, zero when no register of this channel is read
    always_comb begin
        if (mode_rd)      bus_rdata = mode_q;
        else if (stat_rd) bus_rdata = stat;
        else if (hold_rd) bus_rdata = rx_data;
        else              bus_rdata = '0;
    end

    // R7: receiver reset command is followed by the flush strobe
    a_r7_rx_flush_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.rx_rst |=> rx_flush);
    a_r7_tx_flush_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.tx_rst |=> tx_flush);
    // R12: a holding write always reaches the transmit FIFO strobe
    a_r12_push_on_hold_wr: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wr |-> tx_push);
endmodule

// File: tb/sim_sercfg_chan.sv
`timescale 1ns/1ps
// Bench for sercfg_chan, instance placed at channel index 1 (base 0x8).
module sim_sercfg_chan;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_avail = 0, rx_full = 0, tx_space = 0, tx_idle = 0;
    logic       head_par_err = 0, head_frm_err = 0, rx_ovr_evt = 0, rx_brk_evt = 0;
    logic [7:0] rx_data = '0;
    logic       rx_en, tx_en, rx_flush, tx_flush, line_brk, brk_change;
    logic [1:0] word_len;
    logic       par_en, par_odd, stop_two, fifo_en, tx_half;
    logic [2:0] baud_ext;
    logic [7:0] clk_sel, tx_data;
    logic       tx_push, rx_pop;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic       push_seen;
    logic [7:0] push_val;
    logic [7:0] rd_val;
    logic       pop_seen;

    always #10 clk = ~clk;   // 50 MHz

    sercfg_chan #(.ADDR_W(4), .CH_IDX(1)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_avail(rx_avail), .rx_full(rx_full), .tx_space(tx_space), .tx_idle(tx_idle),
        .head_par_err(head_par_err), .head_frm_err(head_frm_err),
        .rx_ovr_evt(rx_ovr_evt), .rx_brk_evt(rx_brk_evt), .rx_data(rx_data),
        .rx_en(rx_en), .tx_en(tx_en), .rx_flush(rx_flush), .tx_flush(tx_flush),
        .line_brk(line_brk), .brk_change(brk_change), .word_len(word_len),
        .par_en(par_en), .par_odd(par_odd), .stop_two(stop_two), .fifo_en(fifo_en),
        .tx_half(tx_half), .baud_ext(baud_ext), .clk_sel(clk_sel),
        .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #5;
        push_seen = tx_push; push_val = tx_data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #5;
        rd_val = bus_rdata; pop_seen = rx_pop;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Vector: {mr1, mr2, word_len, par_en, par_odd, stop_two}
    localparam logic [20:0] VEC [6] = '{
        {8'h00, 8'h07, 2'd0, 1'b1, 1'b0, 1'b0},
        {8'h05, 8'h0F, 2'd1, 1'b1, 1'b1, 1'b1},
        {8'h12, 8'h07, 2'd2, 1'b0, 1'b0, 1'b0},
        {8'h13, 8'h0F, 2'd3, 1'b0, 1'b0, 1'b1},
        {8'h04, 8'h07, 2'd0, 1'b1, 1'b1, 1'b0},
        {8'h11, 8'h0F, 2'd1, 1'b0, 1'b0, 1'b1}
    };

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got 0x1 expected 0x0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // Reset state
        check("R2 reset rx_en", {7'd0, rx_en}, 8'h00);
        check("R2 reset tx_en", {7'd0, tx_en}, 8'h00);
        check("R11 reset line_brk", {7'd0, line_brk}, 8'h00);
        tx_space = 1; tx_idle = 1;
        rd(4'h9);
        check("R8 status with transmitter disabled", rd_val, 8'h00);

        // R3: reset pointer at MR1, then MR2, then stays at MR2
        wr(4'h8, 8'h13);
        check("R3 first write reaches MR1 word_len", {6'd0, word_len}, 8'h03);
        check("R3 first write reaches MR1 par_en", {7'd0, par_en}, 8'h00);
        wr(4'h8, 8'h0F);
        check("R3 second write reaches MR2", {7'd0, stop_two}, 8'h01);
        wr(4'h8, 8'h07);
        check("R3 pointer saturates at MR2", {7'd0, stop_two}, 8'h00);
        check("R3 MR1 untouched by third write", {6'd0, word_len}, 8'h03);

        // R4 R5: table of frame formats
        for (int i = 0; i < 6; i++) begin
            wr(4'hA, 8'h10);
            wr(4'h8, VEC[i][20:13]);
            wr(4'h8, VEC[i][12:5]);
            check("R4 word_len", {6'd0, word_len}, {6'd0, VEC[i][4:3]});
            check("R4 par_en", {7'd0, par_en}, {7'd0, VEC[i][2]});
            check("R4 par_odd", {7'd0, par_odd}, {7'd0, VEC[i][1]});
            check("R5 stop_two", {7'd0, stop_two}, {7'd0, VEC[i][0]});
            rd(4'h8);
            check("R3 readback of pointed MR2", rd_val, VEC[i][12:5]);
        end

        // R6: MR0 through pointer command 0xB
        wr(4'hA, 8'hB0);
        wr(4'h8, 8'h1D);
        check("R6 fifo_en", {7'd0, fifo_en}, 8'h01);
        check("R6 tx_half", {7'd0, tx_half}, 8'h01);
        check("R6 baud_ext", {5'd0, baud_ext}, 8'h05);
        wr(4'h8, 8'h03);
        check("R3 MR0 write advances to MR1", {6'd0, word_len}, 8'h03);
        wr(4'hA, 8'hB0);
        rd(4'h8);
        check("R3 readback of MR0", rd_val, 8'h1D);

        // R2: enables and priority
        wr(4'hA, 8'h05);
        check("R2 rx enable", {7'd0, rx_en}, 8'h01);
        check("R2 tx enable", {7'd0, tx_en}, 8'h01);
        wr(4'hA, 8'h02);
        check("R2 rx disable", {7'd0, rx_en}, 8'h00);
        check("R2 tx kept", {7'd0, tx_en}, 8'h01);
        wr(4'hA, 8'h0C);
        check("R2 tx disable wins over enable", {7'd0, tx_en}, 8'h00);
        wr(4'hA, 8'h05);

        // R1: other channel window is ignored
        wr(4'h2, 8'h0A);
        check("R1 foreign command ignored rx", {7'd0, rx_en}, 8'h01);
        check("R1 foreign command ignored tx", {7'd0, tx_en}, 8'h01);
        wr(4'h1, 8'h77);
        check("R1 foreign clock select ignored", clk_sel, 8'h00);
        wr(4'h0, 8'h00);
        rd(4'h8);
        check("R1 foreign mode write ignored", rd_val, 8'h1D);

        // R13: clock select write, status read at same offset
        wr(4'h9, 8'hBB);
        check("R13 clk_sel stored", clk_sel, 8'hBB);
        rd(4'h9);
        check("R13 offset 1 reads status", rd_val, 8'h0C);

        // R8: status levels
        @(negedge clk);
        rx_avail = 1; head_par_err = 1;
        rd(4'h9);
        check("R8 status with parity head", rd_val, 8'h2D);
        @(negedge clk);
        rx_avail = 0; rx_full = 1; head_frm_err = 1;
        rd(4'h9);
        check("R8 errors gated without data", rd_val, 8'h0E);
        @(negedge clk);
        rx_full = 0; head_par_err = 0; head_frm_err = 0;

        // R9 R10: sticky flags
        @(negedge clk); rx_ovr_evt = 1;
        @(negedge clk); rx_ovr_evt = 0; rx_brk_evt = 1;
        @(negedge clk); rx_brk_evt = 0;
        idle(2);
        rd(4'h9);
        check("R9 overrun and break latched", rd_val, 8'h9C);
        check("R10 break change latched", {7'd0, brk_change}, 8'h01);
        wr(4'hA, 8'h50);
        check("R10 break change cleared", {7'd0, brk_change}, 8'h00);
        rd(4'h9);
        check("R9 flags survive other clear", rd_val, 8'h9C);
        wr(4'hA, 8'h40);
        rd(4'h9);
        check("R9 error clear", rd_val, 8'h0C);

        // R7: flush pulses, pointer unmoved
        wr(4'hA, 8'hB0);
        wr(4'hA, 8'h20);
        check("R7 rx_flush pulse", {7'd0, rx_flush}, 8'h01);
        check("R7 tx_flush quiet", {7'd0, tx_flush}, 8'h00);
        idle(1);
        check("R7 rx_flush one cycle", {7'd0, rx_flush}, 8'h00);
        wr(4'hA, 8'h30);
        check("R7 tx_flush pulse", {7'd0, tx_flush}, 8'h01);
        wr(4'h8, 8'h08);
        check("R7 pointer kept at MR0 fifo_en", {7'd0, fifo_en}, 8'h01);
        check("R7 pointer kept at MR0 tx_half", {7'd0, tx_half}, 8'h00);

        // R11: break waits for idle, holds until stop
        @(negedge clk); tx_idle = 0;
        wr(4'hA, 8'h60);
        idle(2);
        check("R11 break waits for idle", {7'd0, line_brk}, 8'h00);
        tx_idle = 1;
        idle(1);
        check("R11 break asserted", {7'd0, line_brk}, 8'h01);
        tx_idle = 0;
        wr(4'hA, 8'h40);
        idle(2);
        check("R11 break holds", {7'd0, line_brk}, 8'h01);
        wr(4'hA, 8'h70);
        check("R11 break released", {7'd0, line_brk}, 8'h00);

        // R12: holding register strobes
        wr(4'hB, 8'h5A);
        check("R12 tx_push", {7'd0, push_seen}, 8'h01);
        check("R12 tx_data", push_val, 8'h5A);
        rx_data = 8'h3C;
        rd(4'hB);
        check("R12 rx data read", rd_val, 8'h3C);
        check("R12 rx_pop", {7'd0, pop_seen}, 8'h01);
        rd(4'h3);
        check("R1 foreign holding read no pop", {7'd0, pop_seen}, 8'h00);
        wr(4'h3, 8'h11);
        check("R1 foreign holding write no push", {7'd0, push_seen}, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule